// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Detector

This block watches a bank of already debounced input pins and turns level or edge activity on each one into two sticky flags: an interrupt flag and a wake flag. Each pin has its own sensing controls, an interrupt enable, a delivery mask and three wake enables, one per sleep depth. The block combines the two flags with the mask into a per-pin request line for the next level of interrupt aggregation. Software clears either flag by pulsing a write-one-to-clear strobe for that pin.

A chip-wide hold input stops every pin from raising new flags while it is asserted, for example while debounce settings settle after a reprogramming write. During the hold, each pin's enable reads back as 0. Flags that are already set stay set, and clears still take effect.

Top module: `gpio_evt_detect`

## Requirements
- R1: While reset is asserted and after its release, every interrupt flag, wake flag and request output is 0.
- R2: With the sense bit at 1 (level), polarity code 00 raises an event in every cycle the pin is 1, and code 01 raises one in every cycle the pin is 0. A flag cleared while the level is still active is set again on the following clock edge.
- R3: With the sense bit at 0 (edge), each pin's level is compared with the registered level from the previous cycle. Code 00 reacts to a 0-to-1 change, code 01 to a 1-to-0 change and code 10 to either change.
- R4: Polarity code 10 combined with level sensing produces no event, and so does code 11 in either sensing mode.
- R5: An event sets the interrupt flag only while that pin's interrupt enable is 1. Dropping the enable leaves a flag that is already set unchanged.
- R6: A 1 on a pin's interrupt-clear or wake-clear strobe clears that flag on the next edge. An event in the same cycle takes priority, so the flag stays set.
- R7: An event sets the wake flag when the wake enable for the current power state is 1. The power-state encoding is 00 = running (no wake), 01 = light idle, 10 = suspend-to-RAM and 11 = soft-off. The wake flag does not depend on the interrupt enable.
- R8: A pin's request output is 1 exactly when its interrupt flag or its wake flag is set and its mask bit is 1 (1 = delivered).
- R9: While the global hold is 1, every enable read-back is 0 and no flag of either kind becomes set. Existing flags keep their values unless they are cleared.
- R10: The first cycle after reset release detects no edge, whatever level the pin had during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | PINS | Debounced pin levels |
| trig_lvl | input | PINS | Sense type per pin: 1 = level, 0 = edge |
| act_sel | input | 2*PINS | Polarity code per pin, pin i at bits [2i+1:2i] |
| irq_en | input | PINS | Interrupt enable per pin |
| irq_unmask | input | PINS | Mask per pin, 1 = delivered |
| wake_en_idle | input | PINS | Wake enable in light idle |
| wake_en_susp | input | PINS | Wake enable in suspend-to-RAM |
| wake_en_off | input | PINS | Wake enable in soft-off |
| pwr_state | input | 2 | Current power state (encoding in R7) |
| gen_block | input | 1 | Global hold on flag generation |
| clr_int | input | PINS | Write-one-to-clear strobe for the interrupt flags |
| clr_wake | input | PINS | Write-one-to-clear strobe for the wake flags |
| int_sts | output | PINS | Sticky interrupt flags |
| wake_sts | output | PINS | Sticky wake flags |
| irq_req | output | PINS | Pending and delivered request per pin |
| irq_en_rd | output | PINS | Enable read-back, forced to 0 during the hold |

## Verification
The bench builds the block with PINS = 3. This is a width that no power of two gives, so the per-pin slicing of the two-bit polarity field is exercised at odd and nonzero indices, and each pin can sit in a different sensing mode at the same time. Control settings change every sixteen cycles while the pin levels change every cycle. Over the run this reaches every combination of sense type, polarity code and power state, including clears that land on the same cycle as an event and holds that arrive while flags are already set.

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_lvl,
  input  logic [PINS-1:0]   trig_lvl,
  input  logic [2*PINS-1:0] act_sel,
  input  logic [PINS-1:0]   irq_en,
  input  logic [PINS-1:0]   irq_unmask,
  input  logic [PINS-1:0]   wake_en_idle,
  input  logic [PINS-1:0]   wake_en_susp,
  input  logic [PINS-1:0]   wake_en_off,
  input  logic [1:0]        pwr_state,
  input  logic              gen_block,
  input  logic [PINS-1:0]   clr_int,
  input  logic [PINS-1:0]   clr_wake,
  output logic [PINS-1:0]   int_sts,
  output logic [PINS-1:0]   wake_sts,
  output logic [PINS-1:0]   irq_req,
  output logic [PINS-1:0]   irq_en_rd
);
  localparam logic [1:0] SEL_HIGH = 2'b00;
  localparam logic [1:0] SEL_LOW  = 2'b01;
  localparam logic [1:0] SEL_BOTH = 2'b10;

  logic            armed_q;
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] wake_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= '0;
    end else begin
      armed_q <= 1'b1;
      prev_q  <= pin_lvl;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] sel;
    logic       rise, fall;
    assign sel  = act_sel[2*i +: 2];
    assign rise = armed_q & pin_lvl[i] & ~prev_q[i];
    assign fall = armed_q & ~pin_lvl[i] & prev_q[i];

    always_comb begin
      hit[i] = 1'b0;
      if (trig_lvl[i]) begin
        case (sel)
          SEL_HIGH: hit[i] = pin_lvl[i];
          SEL_LOW:  hit[i] = ~pin_lvl[i];
          default:  hit[i] = 1'b0;
        endcase
      end else begin
        case (sel)
          SEL_HIGH: hit[i] = rise;
          SEL_LOW:  hit[i] = fall;
          SEL_BOTH: hit[i] = rise | fall;
          default:  hit[i] = 1'b0;
        endcase
      end
    end

    always_comb begin
      case (pwr_state)
        2'b01:   wake_sel[i] = wake_en_idle[i];
        2'b10:   wake_sel[i] = wake_en_susp[i];
        2'b11:   wake_sel[i] = wake_en_off[i];
        default: wake_sel[i] = 1'b0;
      endcase
    end
  end

  wire [PINS-1:0] live     = hit & {PINS{~gen_block}};
  wire [PINS-1:0] set_int  = live & irq_en;
  wire [PINS-1:0] set_wake = live & wake_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_sts  <= '0;
      wake_sts <= '0;
    end else begin
      int_sts  <= (int_sts & ~clr_int) | set_int;
      wake_sts <= (wake_sts & ~clr_wake) | set_wake;
    end
  end

  assign irq_req   = (int_sts | wake_sts) & irq_unmask;
  assign irq_en_rd = irq_en & {PINS{~gen_block}};
endmodule

// File: rtl/gpio_evt_detect_chk.sv
module gpio_evt_detect_chk #(
  parameter int PINS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PINS-1:0]   pin_lvl,
  input logic [PINS-1:0]   trig_lvl,
  input logic [2*PINS-1:0] act_sel,
  input logic [PINS-1:0]   irq_en,
  input logic [PINS-1:0]   irq_unmask,
  input logic [PINS-1:0]   wake_en_idle,
  input logic [PINS-1:0]   wake_en_susp,
  input logic [PINS-1:0]   wake_en_off,
  input logic [1:0]        pwr_state,
  input logic              gen_block,
  input logic [PINS-1:0]   clr_int,
  input logic [PINS-1:0]   clr_wake,
  input logic [PINS-1:0]   int_sts,
  input logic [PINS-1:0]   wake_sts,
  input logic [PINS-1:0]   irq_req,
  input logic [PINS-1:0]   irq_en_rd
);
  for (genvar i = 0; i < PINS; i++) begin : g_chk
    assert_level_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_lvl[i] && act_sel[2*i +: 2] == 2'b00 && pin_lvl[i] && irq_en[i] && !gen_block
      |=> int_sts[i]);
    assert_keep_on_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en[i] && int_sts[i] && !clr_int[i] |=> int_sts[i]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_int[i] && !irq_en[i] |=> !int_sts[i]);
    assert_no_wake_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state == 2'b00 && !wake_sts[i] |=> !wake_sts[i]);
    assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] |-> irq_unmask[i] && (int_sts[i] || wake_sts[i]));
    assert_en_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gen_block |-> !irq_en_rd[i]);
    assert_no_new_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gen_block && !int_sts[i] |=> !int_sts[i]);
    assert_no_new_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gen_block && !wake_sts[i] |=> !wake_sts[i]);
  end
endmodule

bind gpio_evt_detect gpio_evt_detect_chk #(.PINS(PINS)) u_chk (.*);

// File: tb/sim_gpio_evt_detect.sv
`timescale 1ns/1ps
module sim_gpio_evt_detect;
  localparam int NP = 3;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pin_lvl = '0, trig_lvl = '0, irq_en = '0, irq_unmask = '0;
  logic [NP-1:0] wake_en_idle = '0, wake_en_susp = '0, wake_en_off = '0;
  logic [NP-1:0] clr_int = '0, clr_wake = '0;
  logic [2*NP-1:0] act_sel = '0;
  logic [1:0] pwr_state = '0;
  logic gen_block = 0;
  logic [NP-1:0] int_sts, wake_sts, irq_req, irq_en_rd;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [NP-1:0] m_prev, m_int, m_wake;
  logic m_armed;

  always #5 clk = ~clk;

  gpio_evt_detect #(.PINS(NP)) u0 (.*);

  function automatic bit f_hit(bit trig, bit [1:0] sel, bit lvl, bit prv, bit armed);
    if (trig) return (sel == 2'b00) ? lvl : (sel == 2'b01) ? !lvl : 1'b0;
    case (sel)
      2'b00:   return armed && lvl && !prv;
      2'b01:   return armed && !lvl && prv;
      2'b10:   return armed && (lvl != prv);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit f_wsel(int p);
    case (pwr_state)
      2'b01:   return wake_en_idle[p];
      2'b10:   return wake_en_susp[p];
      2'b11:   return wake_en_off[p];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, string ctx, logic [NP-1:0] got, logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s): got %b expected %b", tag, ctx, got, exp);
    end
  endtask

  task automatic step(string ctx);
    logic [NP-1:0] n_int, n_wake;
    for (int p = 0; p < NP; p++) begin
      bit h;
      h = f_hit(trig_lvl[p], act_sel[2*p +: 2], pin_lvl[p], m_prev[p], m_armed) && !gen_block;
      n_int[p]  = (m_int[p] && !clr_int[p]) || (h && irq_en[p]);
      n_wake[p] = (m_wake[p] && !clr_wake[p]) || (h && f_wsel(p));
    end
    @(posedge clk);
    #1;
    m_int = n_int; m_wake = n_wake; m_prev = pin_lvl; m_armed = 1;
    chk("R2/R3/R4/R5/R6", ctx, int_sts, m_int);
    chk("R7", ctx, wake_sts, m_wake);
    chk("R8", ctx, irq_req, (m_int | m_wake) & irq_unmask);
    chk("R9", ctx, irq_en_rd, irq_en & {NP{~gen_block}});
    @(negedge clk);
    clr_int = '0; clr_wake = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R10 setup: rising-edge mode, pins high through reset
    trig_lvl = '0; act_sel = '0; irq_en = '1; irq_unmask = '1; pin_lvl = '1;
    m_prev = '0; m_int = '0; m_wake = '0; m_armed = 0;
    repeat (3) @(negedge clk);
    chk("R1", "in reset", int_sts | wake_sts | irq_req, '0);
    rst_n = 1;
    step("first cycle after reset");
    chk("R10", "no edge from reset level", int_sts, '0);
    chk("R1", "after reset", wake_sts, '0);
    pin_lvl = '0; step("R3 fall in rising mode");
    pin_lvl = '1; step("R3 rise");
    chk("R3", "rising edge sets", int_sts, '1);
    clr_int = '1; step("R6 clear");
    chk("R6", "cleared", int_sts, '0);
    // R4: level with both-edge code, and code 11
    trig_lvl = '1; act_sel = {2'b10, 2'b10, 2'b10};
    pin_lvl = '0; step("R4 level+both"); pin_lvl = '1; step("R4 level+both");
    trig_lvl = '0; act_sel = {2'b11, 2'b11, 2'b11};
    pin_lvl = '0; step("R4 code 11"); pin_lvl = '1; step("R4 code 11");
    chk("R4", "no event", int_sts, '0);
    // R2/R6: level high, clear collides with active level
    trig_lvl = '1; act_sel = '0;
    step("R2 level"); clr_int = '1; step("R6 set wins");
    chk("R6", "set beats clear", int_sts, '1);
    // R5: disable keeps status
    irq_en = '0; pin_lvl = '0; step("R5 disable"); step("R5 hold");
    chk("R5", "kept after disable", int_sts, '1);
    clr_int = '1; step("R5 clear");
    // R7: wake per state, interrupt disabled
    wake_en_susp = 3'b010; pwr_state = 2'b10; act_sel = {2'b01, 2'b01, 2'b01};
    step("R7 suspend");
    chk("R7", "suspend wake only pin1", wake_sts, 3'b010);
    // R9: hold blocks new flags
    clr_wake = '1; gen_block = 1; irq_en = '1; wake_en_susp = '1; step("R9 hold");
    chk("R9", "nothing new", int_sts | wake_sts, '0);
    chk("R9", "enable hidden", irq_en_rd, '0);
    gen_block = 0; step("R9 released");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      if (n % 16 == 0) begin
        trig_lvl = NP'($urandom); act_sel = (2*NP)'($urandom);
        irq_en = NP'($urandom); irq_unmask = NP'($urandom);
        wake_en_idle = NP'($urandom); wake_en_susp = NP'($urandom);
        wake_en_off = NP'($urandom); pwr_state = 2'($urandom);
      end
      pin_lvl = NP'($urandom);
      gen_block = ($urandom % 8) == 0;
      for (int p = 0; p < NP; p++) begin
        clr_int[p]  = ($urandom % 4) == 0;
        clr_wake[p] = ($urandom % 4) == 0;
      end
      step("random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule